// File: doc/BRIEF.md
# Memory-Mapped BCD Real-Time Clock

This block is a calendar clock that lives inside an 8K x 8 byte-addressed memory space. The top eight byte locations hold a control byte and seven timekeeping bytes (seconds, minutes, hours, day of week, date, month, year), all in packed BCD. Every other location is plain read/write storage, written so that block RAM can be inferred. A one-cycle synchronous bus port reaches both regions with the same read and write protocol.

Time advances once per second. The second is derived by a prescaler that counts pulses of a reference enable (nominally 32,768 per second). The counters apply a 24-hour day, months of 28, 29, 30 or 31 days, and leap years. The control byte lets software freeze the visible bytes for a consistent read, or freeze them, rewrite them and commit a new time. It also holds a signed trim that lengthens or shortens one second per minute. A square-wave test output shows the prescaler phase so the timebase can be checked from outside.

Top module: `bcd_rtc_ram`

## Requirements
- R1: Addresses 0000h to 1FF7h behave as byte RAM. A byte written there reads back unchanged, and read data appears on rdata in the cycle after a read request (cs=1, we=0) and holds until the next read.
- R2: The clock bytes are 1FF8h control, 1FF9h seconds, 1FFAh minutes, 1FFBh hours, 1FFCh day of week, 1FFDh date, 1FFEh month and 1FFFh year. After reset they read 00, 00, 00, 00, 01, 01, 01, 00 in that address order.
- R3: Seconds and minutes count in BCD from 00 to 59. Each low nibble carries into its high nibble after 9, and 59 wraps to 00 with a carry into the next byte.
- R4: Hours count 00 to 23 in BCD. On 23 to 00 the day of week advances (01 to 07, with 07 wrapping to 01) and so does the date.
- R5: The date wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. In month 02 it wraps after 28, or after 29 when the year value is divisible by four (00 included). Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R6: Control bit 7 is the write bit. While it is set, the seven time bytes stop following the counters and accept bus writes. Writing the control byte with bit 7 clear while it was set copies all seven bytes into the counters and restarts the current second.
- R7: Control bit 6 is the read bit. While it is set, the time bytes hold a frozen copy while the counters keep running, and clearing it shows the advanced time. Writes to time bytes while bit 7 is clear have no effect.
- R8: One second lasts PRESCALE cycles with ref_en high. Cycles with ref_en low do not advance the prescaler.
- R9: Control bits 5:0 hold a trim with sign in bit 5 and magnitude in bits 4:0. The second that begins with the seconds byte at 00 lasts PRESCALE plus the magnitude ref_en pulses when bit 5 is 0, and PRESCALE minus the magnitude when bit 5 is 1. All other seconds last PRESCALE pulses.
- R10: ft_out is a registered square wave that is high for the first PRESCALE/2 ref_en pulses of each second and low for the rest, so its rising edges are one second apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One-cycle pulse per reference clock period |
| cs | input | 1 | Bus access request |
| we | input | 1 | 1 = write, 0 = read (with cs) |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after a read |
| ft_out | output | 1 | Timebase test square wave |

## Verification
A table of preset times is committed through the write bit, and the bytes are read after exactly one tick. The presets are chosen to separate the rollovers: a plain second step, nibble carries inside seconds, minutes and hours, and the midnight carry into day of week and date. They also cover each month length, February in a leap year, a non-leap year and year 00, and the year-end wrap from 99. Directed cases distinguish the read bit from the write bit (frozen view versus committed load), show that time-byte writes are ignored when bit 7 is clear, and show that ref_en low stalls time. Edge-to-edge timing on ft_out separates a positive trim, a negative trim and the untrimmed second, and also measures the high phase width.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int CAL_W  = 6;

  typedef logic [BYTE_W-1:0] bcd_t;

  typedef struct packed {
    bcd_t yr;
    bcd_t mon;
    bcd_t date;
    bcd_t dow;
    bcd_t hrs;
    bcd_t mins;
    bcd_t secs;
  } time_t;

  localparam time_t TIME_RST = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                                 hrs: 8'h00, mins: 8'h00, secs: 8'h00};

  // next BCD value of a two-digit byte
  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(bcd_t y);
    logic [7:0] b;
    b = 8'(y[7:4]) * 8'd10 + 8'(y[3:0]);
    return b[1:0] == 2'b00;
  endfunction

  function automatic bcd_t month_len(bcd_t m, bcd_t y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 8184,
  parameter int WIDTH  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler import rtc_pkg::*; #(
  parameter int PRESCALE = 32768
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_en,
  input  logic             restart,
  input  logic             adjust,
  input  logic [CAL_W-1:0] cal,
  output logic             tick,
  output logic             ft_out
);
  localparam int CNT_W = $clog2(PRESCALE + (1 << (CAL_W - 1))) + 1;
  localparam int HALF  = PRESCALE / 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] mag;

  assign mag = CNT_W'(cal[CAL_W-2:0]);

  always_comb begin
    term = CNT_W'(PRESCALE - 1);
    if (adjust) term = cal[CAL_W-1] ? term - mag : term + mag;
  end

  assign tick = ref_en && (cnt >= term);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (ref_en)    cnt <= tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ft_out <= 1'b0;
    else     ft_out <= (cnt < CNT_W'(HALF));
  end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter import rtc_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  load,
  input  time_t load_val,
  output time_t now
);
  time_t nxt;

  always_comb begin
    nxt = now;
    if (now.secs < 8'h59) nxt.secs = bcd_inc(now.secs);
    else begin
      nxt.secs = 8'h00;
      if (now.mins < 8'h59) nxt.mins = bcd_inc(now.mins);
      else begin
        nxt.mins = 8'h00;
        if (now.hrs < 8'h23) nxt.hrs = bcd_inc(now.hrs);
        else begin
          nxt.hrs = 8'h00;
          nxt.dow = (now.dow >= 8'h07) ? 8'h01 : bcd_inc(now.dow);
          if (now.date < month_len(now.mon, now.yr)) nxt.date = bcd_inc(now.date);
          else begin
            nxt.date = 8'h01;
            if (now.mon < 8'h12) nxt.mon = bcd_inc(now.mon);
            else begin
              nxt.mon = 8'h01;
              nxt.yr  = (now.yr >= 8'h99) ? 8'h00 : bcd_inc(now.yr);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       now <= TIME_RST;
    else if (load) now <= load_val;
    else if (tick) now <= nxt;
  end
endmodule

// File: rtl/bcd_rtc_ram.sv
module bcd_rtc_ram import rtc_pkg::*; #(
  parameter int ADDR_W   = 13,
  parameter int PRESCALE = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_en,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              ft_out
);
  localparam int SEL_W     = 3;
  localparam int RAM_DEPTH = (1 << ADDR_W) - (1 << SEL_W);

  logic             hit_clk;
  logic [SEL_W-1:0] sel;
  logic [BYTE_W-1:0] ctl;
  logic             wr_ctl, wr_tbyte, wr_ram, rd_ram, rd_clk;
  logic             load, freeze, tick;
  time_t            now, user;
  logic [BYTE_W-1:0] clk_byte, clk_q, ram_q;
  logic             use_clk;

  assign hit_clk  = &addr[ADDR_W-1:SEL_W];
  assign sel      = addr[SEL_W-1:0];
  assign wr_ctl   = cs && we && hit_clk && (sel == '0);
  assign wr_tbyte = cs && we && hit_clk && (sel != '0);
  assign wr_ram   = cs && we && !hit_clk;
  assign rd_ram   = cs && !we && !hit_clk;
  assign rd_clk   = cs && !we && hit_clk;
  assign freeze   = ctl[7] || ctl[6];
  assign load     = wr_ctl && ctl[7] && !wdata[7];

  always_ff @(posedge clk) begin
    if (rst)         ctl <= '0;
    else if (wr_ctl) ctl <= wdata;
  end

  // user-visible time bytes: follow counters unless frozen
  always_ff @(posedge clk) begin
    if (rst) user <= TIME_RST;
    else if (!freeze) user <= now;
    else if (wr_tbyte && ctl[7]) begin
      case (sel)
        3'd1:    user.secs <= wdata;
        3'd2:    user.mins <= wdata;
        3'd3:    user.hrs  <= wdata;
        3'd4:    user.dow  <= wdata;
        3'd5:    user.date <= wdata;
        3'd6:    user.mon  <= wdata;
        default: user.yr   <= wdata;
      endcase
    end
  end

  always_comb begin
    case (sel)
      3'd0:    clk_byte = ctl;
      3'd1:    clk_byte = user.secs;
      3'd2:    clk_byte = user.mins;
      3'd3:    clk_byte = user.hrs;
      3'd4:    clk_byte = user.dow;
      3'd5:    clk_byte = user.date;
      3'd6:    clk_byte = user.mon;
      default: clk_byte = user.yr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q   <= '0;
      use_clk <= 1'b1;
    end else begin
      if (rd_clk)     clk_q   <= clk_byte;
      if (cs && !we)  use_clk <= hit_clk;
    end
  end

  assign rdata = use_clk ? clk_q : ram_q;

  rtc_ram #(.ADDR_W(ADDR_W), .DEPTH(RAM_DEPTH), .WIDTH(BYTE_W)) ram_i (
    .clk(clk), .we(wr_ram), .re(rd_ram), .addr(addr), .wdata(wdata), .rdata(ram_q)
  );

  rtc_prescaler #(.PRESCALE(PRESCALE)) pre_i (
    .clk(clk), .rst(rst), .ref_en(ref_en), .restart(load),
    .adjust(now.secs == 8'h00), .cal(ctl[CAL_W-1:0]),
    .tick(tick), .ft_out(ft_out)
  );

  rtc_time_counter cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_val(user), .now(now)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker import rtc_pkg::*; (
  input logic  clk,
  input logic  rst,
  input logic  ref_en,
  input logic  tick,
  input logic  load,
  input time_t now,
  input time_t user,
  input logic  freeze,
  input logic  bus_wr
);
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && now.secs == 8'h59) |=> (now.secs == 8'h00));

  p_hour_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && now.secs == 8'h59 && now.mins == 8'h59 && now.hrs == 8'h23)
      |=> (now.hrs == 8'h00));

  p_year_end_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && now.secs == 8'h59 && now.mins == 8'h59 && now.hrs == 8'h23 &&
     now.date == 8'h31 && now.mon == 8'h12) |=> (now.mon == 8'h01 && now.date == 8'h01));

  p_load_copy_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> (now == $past(user)));

  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (freeze && !bus_wr) |=> $stable(user));

  p_tick_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !ref_en |-> !tick);
endmodule

bind bcd_rtc_ram rtc_checker chk_i (
  .clk(clk), .rst(rst), .ref_en(ref_en), .tick(tick), .load(load),
  .now(now), .user(user), .freeze(freeze), .bus_wr(cs && we)
);

// File: tb/bcd_rtc_ram_tb_top.sv
module bcd_rtc_ram_tb_top;
  localparam int ADDR_W = 13;
  localparam int PRE    = 64;
  localparam logic [12:0] CTL_A = 13'h1FF8;
  localparam int NVEC = 13;

  // {in, expected}, each {sec,min,hr,dow,date,mon,yr}
  localparam logic [111:0] VECS [NVEC] = '{
    {56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00},
    {56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00},
    {56'h59_59_23_03_28_02_23, 56'h00_00_00_04_01_03_23},
    {56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24},
    {56'h59_59_23_03_29_02_24, 56'h00_00_00_04_01_03_24},
    {56'h59_59_23_05_30_04_10, 56'h00_00_00_06_01_05_10},
    {56'h59_59_23_05_30_05_10, 56'h00_00_00_06_31_05_10},
    {56'h59_59_12_02_15_06_00, 56'h00_00_13_02_15_06_00},
    {56'h09_19_09_01_09_09_09, 56'h10_19_09_01_09_09_09},
    {56'h59_09_09_01_09_09_09, 56'h00_10_09_01_09_09_09},
    {56'h59_59_23_03_28_02_00, 56'h00_00_00_04_29_02_00},
    {56'h59_59_23_06_31_01_05, 56'h00_00_00_07_01_02_05},
    {56'h59_59_19_01_30_11_18, 56'h00_00_20_01_30_11_18}
  };

  logic clk = 1'b0, rst = 1'b1, ref_en = 1'b1, cs = 1'b0, we = 1'b0, ft_out;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, failures = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcd_rtc_ram #(.ADDR_W(ADDR_W), .PRESCALE(PRE)) dut_i (
    .clk(clk), .rst(rst), .ref_en(ref_en), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ft_out(ft_out)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a;
    @(negedge clk); cs = 0; d = rdata;
  endtask

  task automatic load_time(input logic [55:0] t, input logic [7:0] c);
    bus_wr(CTL_A, 8'h80);
    for (int k = 1; k <= 7; k++) bus_wr(CTL_A + 13'(k), t[63-8*k -: 8]);
    bus_wr(CTL_A, c);
  endtask

  task automatic read_time(output logic [55:0] t);
    logic [7:0] b;
    for (int k = 1; k <= 7; k++) begin
      bus_rd(CTL_A + 13'(k), b);
      t[63-8*k -: 8] = b;
    end
  endtask

  task automatic wait_ft(input logic lvl, output int t);
    logic prev;
    prev = ft_out;
    while (1) begin
      @(negedge clk);
      if (ft_out == lvl && prev != lvl) begin t = cyc; break; end
      prev = ft_out;
    end
  endtask

  task automatic cal_case(input logic [7:0] c, input int exp_len, input string tag);
    int t0, t1, t2, tf;
    load_time(56'h59_00_00_01_01_01_00, c);
    wait_ft(1'b0, tf);
    wait_ft(1'b1, t0);
    wait_ft(1'b1, t1);
    wait_ft(1'b0, tf);
    wait_ft(1'b1, t2);
    check({tag, " trimmed second"}, 64'(t1 - t0), 64'(exp_len));
    check("R9 untrimmed second", 64'(t2 - t1), 64'(PRE));
    check("R10 ft high width", 64'(tf - t1), 64'(PRE / 2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [55:0] t;
    repeat (3) @(negedge clk);
    rst = 0;

    // R2 reset state
    bus_rd(CTL_A, b);
    check("R2 control after reset", 64'(b), 64'h00);
    read_time(t);
    check("R2 time after reset", 64'(t), 64'h00_00_00_01_01_01_00);

    // R1 RAM
    bus_wr(13'h0000, 8'hA5);
    bus_wr(13'h1FF7, 8'h3C);
    bus_wr(13'h0ABC, 8'h77);
    bus_rd(13'h0000, b); check("R1 ram 0000", 64'(b), 64'hA5);
    bus_rd(13'h1FF7, b); check("R1 ram 1FF7", 64'(b), 64'h3C);
    bus_rd(13'h0ABC, b); check("R1 ram 0ABC", 64'(b), 64'h77);
    @(negedge clk);
    check("R1 rdata held", 64'(rdata), 64'h77);

    // table walk: R3/R4/R5 one tick after commit
    for (int i = 0; i < NVEC; i++) begin
      load_time(VECS[i][111:56], 8'h00);
      repeat (80) @(negedge clk);
      read_time(t);
      check($sformatf("R3/R4/R5 vector %0d", i), 64'(t), 64'(VECS[i][55:0]));
    end

    // R7 writes ignored with write bit clear
    load_time(56'h00_00_00_01_01_01_00, 8'h00);
    bus_wr(CTL_A + 13'd1, 8'h45);
    bus_rd(CTL_A + 13'd1, b);
    check("R7 ignored seconds write", 64'(b), 64'h00);

    // R7 read bit freezes view, counters run
    load_time(56'h00_00_10_01_01_01_00, 8'h00);
    bus_wr(CTL_A, 8'h40);
    repeat (150) @(negedge clk);
    bus_rd(CTL_A + 13'd1, b);
    check("R7 frozen seconds", 64'(b), 64'h00);
    bus_wr(CTL_A, 8'h00);
    bus_rd(CTL_A + 13'd1, b);
    check("R7 released seconds", 64'(b), 64'h02);

    // R6 write bit freezes and commits
    load_time(56'h00_00_00_01_01_01_00, 8'h00);
    bus_wr(CTL_A, 8'h80);
    repeat (150) @(negedge clk);
    bus_rd(CTL_A + 13'd1, b);
    check("R6 frozen under write bit", 64'(b), 64'h00);
    bus_wr(CTL_A + 13'd1, 8'h30);
    bus_wr(CTL_A, 8'h00);
    bus_rd(CTL_A + 13'd1, b);
    check("R6 committed seconds", 64'(b), 64'h30);

    // R8 ref_en gating
    load_time(56'h00_00_00_01_01_01_00, 8'h00);
    ref_en = 0;
    repeat (300) @(negedge clk);
    bus_rd(CTL_A + 13'd1, b);
    check("R8 stalled seconds", 64'(b), 64'h00);
    ref_en = 1;
    repeat (70) @(negedge clk);
    bus_rd(CTL_A + 13'd1, b);
    check("R8 resumed seconds", 64'(b), 64'h01);

    // R9 / R10 trim and test output
    cal_case(8'h05, PRE + 5, "R9 positive");
    cal_case(8'h25, PRE - 5, "R9 negative");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule